// File: doc/BRIEF.md
# Smart card character transceiver

This block moves 8-bit characters over one shared, open-drain smart card I/O line in half-duplex fashion. Each character is a low start bit, eight data bits and a parity bit, followed by a guard time. The block only ever pulls the line low or lets it go; an external pull-up supplies the high level. A baud tick input marks sixteenths of an elementary time unit (etu), and all bit timing is counted in those ticks.

When the receiving side finds a parity mismatch it answers with a low error pulse late in the guard time. The sending side looks at the line at 11 etu and, if the pulse is there, starts the same character again. The transmitter stops after a fixed number of retransmissions and reports a transmit error. Configuration inputs pick the bit order, the level inversion, the parity sense and when the transmit-complete pulse appears, so that both card conventions can be served.

On the system side a byte is offered with a valid/ready pair. A received byte is held with a full flag until acknowledged, and a good character that arrives while the flag is still set is dropped and flagged as overrun.

Top module: `sc_char_xcvr`

## Requirements
- R1: A transmitted frame starts on a baud tick with a start bit driven low, followed by 8 data bits and a parity bit, each lasting 16 ticks (1 etu); the line is pulled low only for 0 bits and is released from 10 etu after the start edge onward.
- R2: With cfg_msb_first=0 data bit 0 is the first data bit on the line; with cfg_msb_first=1 data bit 7 is first. The receiver applies the same order.
- R3: With cfg_invert=1 every data bit and the parity bit appear on the line inverted (0 as high, 1 as low); the start bit stays low. The receiver undoes the inversion.
- R4: With cfg_odd_parity=0 the 8 logical data bits plus the logical parity bit hold an even number of ones; with cfg_odd_parity=1 an odd number.
- R5: A received character with correct parity loads rx_data and sets rx_valid when rx_valid was clear; no error pulse follows. rx_ack while rx_valid is high clears rx_valid.
- R6: A received character with wrong parity loads nothing and is answered by pulling the line low from 10.5 etu to 12 etu after the detected start edge.
- R7: The transmitter samples the line at 11 etu; if it is low, the same character is sent again with its start edge exactly 14 etu (896 clock cycles at 4 clocks per tick) after the previous start edge.
- R8: After MAX_RETRY (3) retransmissions that are all answered with an error pulse, tx_error pulses for one cycle at 12 etu of the last attempt, tx_done does not pulse, and tx_ready returns high.
- R9: tx_done pulses for one cycle only for an accepted character: at 11 etu after the last start edge when cfg_late_end=0, at 12 etu when cfg_late_end=1.
- R10: A character with correct parity that completes while rx_valid is set and not being acknowledged sets rx_overrun and leaves rx_data unchanged; rx_ack clears rx_overrun together with rx_valid.
- R11: The receiver ignores the line while the transmitter holds a character, so the block never receives its own frames or an answering error pulse; tx_ready is low while a character is being received.
- R12: After reset the line is released, tx_ready is high, and rx_valid, rx_overrun, tx_done and tx_error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Baud tick, 16 per etu, one cycle wide |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| cfg_invert | input | 1 | 1: data and parity levels inverted on the line |
| cfg_odd_parity | input | 1 | 1: odd parity, 0: even parity |
| cfg_late_end | input | 1 | 1: tx_done at 12 etu, 0: at 11 etu |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Byte can be accepted |
| tx_done | output | 1 | One-cycle pulse: character accepted by the far end |
| tx_error | output | 1 | One-cycle pulse: retry limit reached |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_data holds an unacknowledged byte |
| rx_overrun | output | 1 | A good character was dropped while rx_valid was set |
| rx_ack | input | 1 | Acknowledges rx_data |
| line_in | input | 1 | Sampled level of the I/O line |
| line_drive_low | output | 1 | 1: pull the I/O line low, 0: release it |

## Verification
Transmitted bytes are decoded bit by bit at mid-etu under all four mixes of order and inversion with both parity senses, so a swapped order, a missing inversion or a wrong parity sense each show up as a distinct bit mismatch. The far-end model answers with zero, one, two and four error pulses, which separates a character accepted first time, retransmissions timed to the cycle, and the give-up path with its error pulse instead of a completion pulse. Received characters are sent with good and with corrupted parity under each convention, telling loading apart from the error pulse, and a second good character without acknowledgement exercises the overrun path.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int SC_DW = 8;

  typedef struct packed {
    logic msb_first;
    logic invert;
    logic odd_parity;
    logic late_end;
  } sc_cfg_t;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,
    TX_FRAME = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_FRAME = 2'd1,
    RX_ERR   = 2'd2
  } rx_state_e;

  // Reverse the bit order when rev is set.
  function automatic logic [SC_DW-1:0] sc_flip(input logic [SC_DW-1:0] d, input logic rev);
    logic [SC_DW-1:0] r;
    for (int i = 0; i < SC_DW; i++) begin
      r[i] = rev ? d[SC_DW-1-i] : d[i];
    end
    return r;
  endfunction

  // Parity bit that makes the total count even (odd=0) or odd (odd=1).
  function automatic logic sc_par(input logic [SC_DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] s_q;
  logic [STAGES-1:0] s_d;

  always_comb begin
    s_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      s_d[i] = s_q[i-1];
    end
  end

  // Idle line level is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '1;
    end else begin
      s_q <= s_d;
    end
  end

  assign q = s_q[STAGES-1];

endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int ETU       = 16,
  parameter int MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  sc_cfg_t          cfg,
  input  logic             line_s,
  input  logic             rx_busy,
  input  logic [SC_DW-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_drv,
  output logic             tx_done,
  output logic             tx_error,
  output logic             tx_active
);

  localparam int SH = $clog2(ETU);
  localparam int CW = $clog2(14 * ETU + 1);
  localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
  localparam int NB = SC_DW + 2;
  localparam logic [CW-1:0] C_BITS = CW'(NB * ETU);
  localparam logic [CW-1:0] C_CHK  = CW'(11 * ETU - 1);
  localparam logic [CW-1:0] C_END  = CW'(12 * ETU - 1);
  localparam logic [CW-1:0] C_RST  = CW'(14 * ETU - 1);

  tx_state_e          state_q, state_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [SC_DW:0]     sym_q, sym_d;
  logic [RW-1:0]      retry_q, retry_d;
  logic               nack_q, nack_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic [NB-1:0]      frame;
  logic [3:0]         bidx;

  assign tx_ready = (state_q == TX_IDLE) && !rx_busy;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sym_d   = sym_q;
    retry_d = retry_q;
    nack_d  = nack_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (tx_valid && tx_ready) begin
          sym_d   = {sc_par(tx_data, cfg.odd_parity) ^ cfg.invert,
                     sc_flip(tx_data, cfg.msb_first) ^ {SC_DW{cfg.invert}}};
          retry_d = '0;
          state_d = TX_ARM;
        end
      end
      TX_ARM: begin
        if (tick) begin
          state_d = TX_FRAME;
          cnt_d   = '0;
          nack_d  = 1'b0;
        end
      end
      TX_FRAME: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == C_CHK) begin
            nack_d = !line_s;
            if (line_s && !cfg.late_end) begin
              done_d = 1'b1;
            end
          end
          if (cnt_q == C_END) begin
            if (nack_q) begin
              if (retry_q == RW'(MAX_RETRY)) begin
                err_d   = 1'b1;
                state_d = TX_IDLE;
              end else begin
                retry_d = retry_q + 1'b1;
              end
            end else begin
              done_d  = cfg.late_end;
              state_d = TX_IDLE;
            end
          end
          if (cnt_q == C_RST) begin
            cnt_d  = '0;
            nack_d = 1'b0;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      sym_q   <= '0;
      retry_q <= '0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sym_q   <= sym_d;
      retry_q <= retry_d;
      nack_q  <= nack_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // Start bit (0) followed by the stored line-level symbols.
  assign frame  = {sym_q, 1'b0};
  assign bidx   = 4'(cnt_q >> SH);
  assign tx_drv = (state_q == TX_FRAME) && (cnt_q < C_BITS) && !frame[bidx];

  assign tx_done   = done_q;
  assign tx_error  = err_q;
  assign tx_active = (state_q != TX_IDLE);

endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int ETU = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  sc_cfg_t          cfg,
  input  logic             line_s,
  input  logic             enable,
  input  logic             rx_ack,
  output logic [SC_DW-1:0] rx_data,
  output logic             rx_valid,
  output logic             rx_overrun,
  output logic             rx_drv,
  output logic             rx_busy
);

  localparam int SH = $clog2(ETU);
  localparam int CW = $clog2(12 * ETU + 1);
  localparam int NB = SC_DW + 2;
  localparam logic [SH-1:0] C_MID  = SH'(ETU / 2 - 1);
  localparam logic [CW-1:0] C_EVAL = CW'(NB * ETU - 1);
  localparam logic [CW-1:0] C_ERR  = CW'(NB * ETU + ETU / 2);
  localparam logic [CW-1:0] C_REL  = CW'(12 * ETU);

  rx_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SC_DW:0]   sh_q, sh_d;
  logic [SC_DW-1:0] data_q, data_d;
  logic             valid_q, valid_d;
  logic             ovr_q, ovr_d;
  logic [3:0]       bidx;
  logic             mid;
  logic [SC_DW-1:0] word;
  logic             pbit;
  logic             par_ok;
  logic             valid_eff;

  assign bidx      = 4'(cnt_q >> SH);
  assign mid       = (cnt_q[SH-1:0] == C_MID);
  assign word      = sc_flip(sh_q[SC_DW-1:0] ^ {SC_DW{cfg.invert}}, cfg.msb_first);
  assign pbit      = sh_q[SC_DW] ^ cfg.invert;
  assign par_ok    = (sc_par(word, cfg.odd_parity) == pbit);
  assign valid_eff = valid_q && !rx_ack;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    data_d  = data_q;
    valid_d = valid_q;
    ovr_d   = ovr_q;
    if (valid_q && rx_ack) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
    case (state_q)
      RX_IDLE: begin
        if (enable && !line_s) begin
          state_d = RX_FRAME;
          cnt_d   = '0;
        end
      end
      RX_FRAME: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (mid) begin
            if (bidx == 4'd0) begin
              if (line_s) begin
                state_d = RX_IDLE;
              end
            end else if (bidx <= 4'(SC_DW + 1)) begin
              sh_d[4'(bidx - 4'd1)] = line_s;
            end
          end
          if (cnt_q == C_EVAL) begin
            if (par_ok) begin
              if (valid_eff) begin
                ovr_d = 1'b1;
              end else begin
                data_d  = word;
                valid_d = 1'b1;
              end
              state_d = RX_IDLE;
            end else begin
              state_d = RX_ERR;
            end
          end
        end
      end
      RX_ERR: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == C_REL) begin
            state_d = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rx_drv     = (state_q == RX_ERR) && (cnt_q >= C_ERR) && (cnt_q < C_REL);
  assign rx_busy    = (state_q != RX_IDLE);
  assign rx_data    = data_q;
  assign rx_valid   = valid_q;
  assign rx_overrun = ovr_q;

endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_pkg::*;
#(
  parameter int ETU         = 16,
  parameter int MAX_RETRY   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_msb_first,
  input  logic       cfg_invert,
  input  logic       cfg_odd_parity,
  input  logic       cfg_late_end,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_done,
  output logic       tx_error,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_overrun,
  input  logic       rx_ack,
  input  logic       line_in,
  output logic       line_drive_low
);

  sc_cfg_t cfg;
  logic    line_s;
  logic    tx_drv;
  logic    rx_drv;
  logic    tx_active;
  logic    rx_busy;

  assign cfg = '{msb_first:  cfg_msb_first,
                 invert:     cfg_invert,
                 odd_parity: cfg_odd_parity,
                 late_end:   cfg_late_end};

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      sc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
      );
    end else begin : g_nosync
      assign line_s = line_in;
    end
  endgenerate

  sc_tx #(.ETU(ETU), .MAX_RETRY(MAX_RETRY)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cfg       (cfg),
    .line_s    (line_s),
    .rx_busy   (rx_busy),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_drv    (tx_drv),
    .tx_done   (tx_done),
    .tx_error  (tx_error),
    .tx_active (tx_active)
  );

  sc_rx #(.ETU(ETU)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cfg        (cfg),
    .line_s     (line_s),
    .enable     (!tx_active),
    .rx_ack     (rx_ack),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun),
    .rx_drv     (rx_drv),
    .rx_busy    (rx_busy)
  );

  assign line_drive_low = tx_drv | rx_drv;

endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_drv,
  input logic       rx_drv,
  input logic       tx_ready,
  input logic       tx_done,
  input logic       tx_error,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_overrun,
  input logic       rx_ack,
  input logic       line_drive_low
);

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_drv && rx_drv)); // R11

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !line_drive_low); // R11

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data))); // R10

  AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_valid); // R10

  AST_DONE_OR_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && tx_error)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R9

endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_drv         (tx_drv),
  .rx_drv         (rx_drv),
  .tx_ready       (tx_ready),
  .tx_done        (tx_done),
  .tx_error       (tx_error),
  .rx_data        (rx_data),
  .rx_valid       (rx_valid),
  .rx_overrun     (rx_overrun),
  .rx_ack         (rx_ack),
  .line_drive_low (line_drive_low)
);

// File: tb/tb_sc_char_xcvr.sv
module tb_sc_char_xcvr;

  localparam int ETUC = 64;   // clocks per etu (4 clocks per tick)
  localparam int LIMIT = 150000;

  // {rx_mode, msb, inv, odd, late, errs[2:0], data[7:0]}
  localparam logic [15:0] VEC [9] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'hA5},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'h3C},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 8'h01},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 8'hF0},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 8'h7E},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h96},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 8'h2D},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 8'h55},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h80}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       cfg_odd_parity = 1'b0;
  logic       cfg_late_end = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       tx_done;
  logic       tx_error;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_overrun;
  logic       rx_ack = 1'b0;
  logic       line_drive_low;
  logic       card_low = 1'b0;
  logic       line;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int done_cyc = 0;
  int err_cnt = 0;
  logic [1:0] tdiv = 2'd0;

  always #5 clk = ~clk;

  assign line = !(line_drive_low || card_low);

  sc_char_xcvr dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .cfg_msb_first  (cfg_msb_first),
    .cfg_invert     (cfg_invert),
    .cfg_odd_parity (cfg_odd_parity),
    .cfg_late_end   (cfg_late_end),
    .tx_data        (tx_data),
    .tx_valid       (tx_valid),
    .tx_ready       (tx_ready),
    .tx_done        (tx_done),
    .tx_error       (tx_error),
    .rx_data        (rx_data),
    .rx_valid       (rx_valid),
    .rx_overrun     (rx_overrun),
    .rx_ack         (rx_ack),
    .line_in        (line),
    .line_drive_low (line_drive_low)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3) && rst_n;
    if (tx_done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
    if (tx_error) err_cnt = err_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Expected line level of frame bit k (0 start, 1..8 data, 9 parity).
  function automatic logic exp_bit(input logic [7:0] d, input int k,
                                   input logic msb, input logic inv, input logic odd);
    if (k == 0) return 1'b0;
    if (k == 9) return (^d) ^ odd ^ inv;
    return (msb ? d[8-k] : d[k-1]) ^ inv;
  endfunction

  task automatic set_cfg(input logic [15:0] v);
    cfg_msb_first  = v[14];
    cfg_invert     = v[13];
    cfg_odd_parity = v[12];
    cfg_late_end   = v[11];
  endtask

  task automatic do_ack();
    @(negedge clk) rx_ack = 1'b1;
    @(negedge clk) rx_ack = 1'b0;
  endtask

  // Far end sends one character; corrupt flips the parity bit.
  task automatic card_send(input logic [7:0] d, input logic corrupt);
    int s0;
    @(negedge clk);
    s0 = cyc;
    for (int k = 0; k < 10; k++) begin
      card_low = !(exp_bit(d, k, cfg_msb_first, cfg_invert, cfg_odd_parity) ^ ((k == 9) && corrupt));
      if (k == 4) chk(tx_ready == 1'b0, "R11 tx_ready low while receiving", tx_ready, 0);
      wait_until(s0 + ETUC * (k + 1));
    end
    card_low = 1'b0;
    wait_until(s0 + 660);
    chk(line_drive_low == 1'b0, "R6 no error pulse before 10.5 etu", line_drive_low, 0);
    wait_until(s0 + 700);
    chk(line_drive_low == corrupt, corrupt ? "R6 error pulse on bad parity" : "R5 no error pulse on good parity",
        line_drive_low, corrupt);
    wait_until(s0 + 790);
    chk(line_drive_low == 1'b0, "R6 error pulse released by 12 etu", line_drive_low, 0);
    wait_until(s0 + 900);
  endtask

  // DUT sends one character; the far end answers errs attempts with an error pulse.
  task automatic dut_send(input logic [15:0] v);
    int errs, tries, t0, tprev, d0, e0;
    logic ok;
    errs  = int'(v[10:8]);
    tries = (errs > 3) ? 4 : errs + 1;
    d0 = done_cnt;
    e0 = err_cnt;
    t0 = 0;
    tprev = 0;
    tx_data = v[7:0];
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    for (int a = 0; a < tries; a++) begin
      while (!line_drive_low) @(negedge clk);
      t0 = cyc;
      if (a > 0) chk(t0 - tprev == 896, "R7 retransmit 14 etu after previous start", t0 - tprev, 896);
      ok = 1'b1;
      for (int k = 0; k < 10; k++) begin
        wait_until(t0 + ETUC / 2 + ETUC * k);
        if (line != exp_bit(v[7:0], k, v[14], v[13], v[12])) begin
          ok = 1'b0;
          $display("  bit %0d of %0h wrong: line=%0b", k, v[7:0], line);
        end
      end
      chk(ok, "R1 R2 R3 R4 transmitted frame bits", ok, 1);
      wait_until(t0 + 660);
      chk(line_drive_low == 1'b0, "R1 line released after parity", line_drive_low, 0);
      if (a < errs) begin
        wait_until(t0 + 672);
        card_low = 1'b1;
        wait_until(t0 + 768);
        card_low = 1'b0;
      end
      tprev = t0;
    end
    wait_until(t0 + 800);
    if (errs > 3) begin
      chk(err_cnt - e0 == 1, "R8 tx_error after retry limit", err_cnt - e0, 1);
      chk(done_cnt - d0 == 0, "R8 no tx_done after retry limit", done_cnt - d0, 0);
    end else begin
      chk(done_cnt - d0 == 1, "R9 one tx_done", done_cnt - d0, 1);
      chk(err_cnt - e0 == 0, "R8 no tx_error within limit", err_cnt - e0, 0);
      chk((done_cyc - t0 >= (v[11] ? 767 : 703)) && (done_cyc - t0 <= (v[11] ? 769 : 705)),
          "R9 tx_done timing", done_cyc - t0, v[11] ? 768 : 704);
    end
    chk(tx_ready == 1'b1, "R8 tx_ready back high", tx_ready, 1);
    chk(rx_valid == 1'b0, "R11 own frame not received", rx_valid, 0);
  endtask

  initial begin
    while (cyc < LIMIT) @(negedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(line_drive_low == 1'b0, "R12 line released in reset", line_drive_low, 0);
    chk(tx_ready == 1'b1, "R12 tx_ready in reset", tx_ready, 1);
    chk(rx_valid == 1'b0 && rx_overrun == 1'b0, "R12 rx flags clear", {rx_valid, rx_overrun}, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(tx_done == 1'b0 && tx_error == 1'b0 && done_cnt == 0, "R12 no pulses after reset",
        {tx_done, tx_error}, 0);

    for (int i = 0; i < 9; i++) begin
      set_cfg(VEC[i]);
      if (!VEC[i][15]) begin
        dut_send(VEC[i]);
      end else begin
        card_send(VEC[i][7:0], VEC[i][8]);
        if (VEC[i][8]) begin
          chk(rx_valid == 1'b0, "R6 bad character not loaded", rx_valid, 0);
        end else begin
          chk(rx_valid == 1'b1 && rx_data == VEC[i][7:0], "R5 R2 R3 R4 received byte",
              {rx_valid, rx_data}, {1'b1, VEC[i][7:0]});
          do_ack();
          chk(rx_valid == 1'b0, "R5 rx_ack clears rx_valid", rx_valid, 0);
        end
      end
    end

    // R10 overrun directed test
    set_cfg(16'h0000);
    card_send(8'h11, 1'b0);
    chk(rx_valid == 1'b1 && rx_data == 8'h11 && rx_overrun == 1'b0, "R10 first byte held",
        {rx_overrun, rx_valid, rx_data}, {2'b01, 8'h11});
    card_send(8'h22, 1'b0);
    chk(rx_overrun == 1'b1 && rx_data == 8'h11, "R10 overrun keeps old data",
        {rx_overrun, rx_data}, {1'b1, 8'h11});
    do_ack();
    chk(rx_valid == 1'b0 && rx_overrun == 1'b0, "R10 ack clears both flags",
        {rx_valid, rx_overrun}, 0);

    // R9 late end after a retransmission at the far end's request
    set_cfg({1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 8'hC3});
    dut_send({1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 8'hC3});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule